// File: doc/BRIEF.md
# Receive-Level RTS and CTS Transmit Gate

This block manages hardware flow control around a 64-entry receive FIFO and a character-oriented transmitter. The FIFO reports its fill count. The block compares that count against two programmable thresholds to decide whether the remote end may keep sending. When the count climbs to the halt level, the active-low RTS output is released (driven high). It is driven low again only once the count has drained to the resume level. Both levels are 4-bit codes scaled by four. Because the two levels are separate, a hysteresis band forms between them. If the automatic mode is off, RTS simply mirrors a software request bit.

In the other direction, the block synchronizes the remote active-low CTS input through a two-flop chain. It then produces a transmit-permit signal for the serializer. When CTS goes high, the permit is withdrawn only at a character boundary, signalled by a one-cycle character-done strobe. The character in flight therefore always finishes. When CTS returns low, the permit comes back on the next cycle.

A third output, the receive trigger flag, tells the interrupt logic that the FIFO has reached its own programmed trigger level. This is independent of the flow-control thresholds.

Top module: `fifo_flow_ctrl`

## Requirements
- R1: While reset is asserted, rts_n is 1, tx_permit is 1 and rx_trig is 0.
- R2: Automatic RTS is active when auto_rts_en=1 and rts_req=1. While it is active, a count of at least halt_code*4 makes rts_n 1 after the next clock edge. A halt code of 0 therefore always halts.
- R3: While automatic RTS is active, a count below the halt level and at or below resume_code*4 makes rts_n 0 after the next clock edge.
- R4: While automatic RTS is active, a count strictly between the resume level and the halt level leaves rts_n unchanged.
- R5: When the count satisfies both the halt and the resume condition (resume level at or above the halt level), halting wins and rts_n becomes 1.
- R6: While automatic RTS is inactive, rts_n becomes the inverse of rts_req after the next clock edge, whatever the count.
- R7: rx_trig becomes 1 after the next clock edge when the count is at least (trig_code+1)*4. Otherwise it becomes 0. The levels run from 4 to 64.
- R8: A change on cts_n reaches tx_permit on the third clock edge after it is presented (two synchronizer stages plus the gate register).
- R9: With auto_cts_en=1, tx_permit falls only after an edge where char_done=1 and the synchronized CTS is high. A high CTS without char_done leaves tx_permit at 1.
- R10: With auto_cts_en=1, a synchronized CTS low sets tx_permit to 1 after the next edge.
- R11: With auto_cts_en=0, tx_permit is 1 after the next edge regardless of cts_n and char_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | 7 | Receive FIFO fill count, 0 to 64 |
| halt_code | input | 4 | Halt threshold code, level = code*4 |
| resume_code | input | 4 | Resume threshold code, level = code*4 |
| trig_code | input | 4 | Receive trigger code, level = (code+1)*4 |
| auto_rts_en | input | 1 | Enable automatic RTS |
| auto_cts_en | input | 1 | Enable CTS gating of the transmitter |
| rts_req | input | 1 | Software RTS request bit |
| cts_n | input | 1 | Remote clear-to-send, active low, asynchronous |
| char_done | input | 1 | One-cycle strobe at the end of a transmitted stop bit |
| rts_n | output | 1 | Request-to-send, active low |
| tx_permit | output | 1 | Serializer may start a new character |
| rx_trig | output | 1 | Receive FIFO at or above trigger level |

## Verification
On every cycle, the in-module assertions check that rts_n follows the halt, resume, hold and manual rules of the previous cycle's inputs. They also check that rx_trig tracks the trigger comparison, and that tx_permit only falls right after a character-done strobe seen with CTS high. Only the bench's scenarios can show certain behaviours: the three-edge latency from a CTS pin change to the permit, the hysteresis sequence through a fill and drain of the FIFO, and halt precedence when the thresholds overlap.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic {
    RTS_ON  = 1'b0,
    RTS_OFF = 1'b1
  } rts_lvl_e;

  // threshold level from a code and a step size
  function automatic int unsigned lvl_scale(input int unsigned code, input int unsigned step);
    return code * step;
  endfunction

  // trigger level: codes 0..15 map to step..16*step
  function automatic int unsigned trig_scale(input int unsigned code, input int unsigned step);
    return (code + 1) * step;
  endfunction
endpackage

// File: rtl/ffc_sync.sv
module ffc_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] stage_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RESET_VAL;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RESET_VAL;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ffc_rts_ctrl.sv
module ffc_rts_ctrl #(
  parameter int CNT_W = 7,
  parameter int LVL_W = 4,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [LVL_W-1:0] halt_code,
  input  logic [LVL_W-1:0] resume_code,
  input  logic             auto_en,
  input  logic             rts_req,
  output logic             rts_n,
  output logic             auto_act,
  output logic             above_halt,
  output logic             below_resume
);
  import ffc_pkg::*;
  localparam int LW = CNT_W + 1;

  logic [LW-1:0] halt_lvl, resume_lvl, cnt_ext;
  rts_lvl_e      rts_q, rts_d;

  assign cnt_ext      = {1'b0, rx_count};
  assign halt_lvl     = LW'(lvl_scale(32'(halt_code), STEP));
  assign resume_lvl   = LW'(lvl_scale(32'(resume_code), STEP));
  assign auto_act     = auto_en & rts_req;
  assign above_halt   = cnt_ext >= halt_lvl;
  assign below_resume = cnt_ext <= resume_lvl;

  always_comb begin
    rts_d = rts_q;
    if (!auto_act)         rts_d = rts_req ? RTS_ON : RTS_OFF;
    else if (above_halt)   rts_d = RTS_OFF;
    else if (below_resume) rts_d = RTS_ON;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= RTS_OFF;
    else        rts_q <= rts_d;
  end

  assign rts_n = rts_q;

  a_r2_halt_on_level: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && above_halt) |=> rts_n);
  a_r3_resume_on_level: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && !above_halt && below_resume) |=> !rts_n);
  a_r4_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && !above_halt && !below_resume) |=> $stable(rts_n));
  a_r6_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_act) |=> (rts_n == !$past(rts_req)));
endmodule

// File: rtl/ffc_cts_gate.sv
module ffc_cts_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_sync,
  input  logic char_done,
  output logic tx_permit
);
  logic permit_q, permit_d;

  always_comb begin
    permit_d = permit_q;
    if (!auto_en)       permit_d = 1'b1;
    else if (!cts_sync) permit_d = 1'b1;
    else if (char_done) permit_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) permit_q <= 1'b1;
    else        permit_q <= permit_d;
  end

  assign tx_permit = permit_q;

  a_r9_fall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_permit) |-> ($past(char_done) && $past(cts_sync)));
  a_r10_resume_on_cts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !cts_sync) |=> tx_permit);
  a_r11_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en) |=> tx_permit);
endmodule

// File: rtl/ffc_trig.sv
module ffc_trig #(
  parameter int CNT_W = 7,
  parameter int LVL_W = 4,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [LVL_W-1:0] trig_code,
  output logic             rx_trig
);
  import ffc_pkg::*;
  localparam int LW = CNT_W + 1;

  logic [LW-1:0] trig_lvl;
  logic          reached;

  assign trig_lvl = LW'(trig_scale(32'(trig_code), STEP));
  assign reached  = {1'b0, rx_count} >= trig_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_trig <= 1'b0;
    else        rx_trig <= reached;
  end

  a_r7_trig_set: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rx_count} >= trig_lvl) |=> rx_trig);
  a_r7_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rx_count} < trig_lvl) |=> !rx_trig);
endmodule

// File: rtl/fifo_flow_ctrl.sv
module fifo_flow_ctrl #(
  parameter int DEPTH       = 64,
  parameter int LVL_W       = 4,
  parameter int STEP        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [LVL_W-1:0] halt_code,
  input  logic [LVL_W-1:0] resume_code,
  input  logic [LVL_W-1:0] trig_code,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             rts_req,
  input  logic             cts_n,
  input  logic             char_done,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             rx_trig
);
  logic cts_sync;
  logic rts_auto_act, rts_above_halt, rts_below_resume;

  ffc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cts_n), .d_sync(cts_sync));

  ffc_rts_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W), .STEP(STEP)) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count),
    .halt_code(halt_code), .resume_code(resume_code),
    .auto_en(auto_rts_en), .rts_req(rts_req), .rts_n(rts_n),
    .auto_act(rts_auto_act), .above_halt(rts_above_halt),
    .below_resume(rts_below_resume));

  ffc_cts_gate u_gate (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_sync(cts_sync),
    .char_done(char_done), .tx_permit(tx_permit));

  ffc_trig #(.CNT_W(CNT_W), .LVL_W(LVL_W), .STEP(STEP)) u_trig (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_code(trig_code),
    .rx_trig(rx_trig));

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));
endmodule

// File: tb/fifo_flow_ctrl_tb.sv
`timescale 1ns/100ps
module fifo_flow_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rx_count = '0;
  logic [3:0] halt_code = '0, resume_code = '0, trig_code = '0;
  logic       auto_rts_en = 1'b0, auto_cts_en = 1'b1, rts_req = 1'b0;
  logic       cts_n = 1'b0, char_done = 1'b0;
  logic       rts_n, tx_permit, rx_trig;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_flow_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .halt_code(halt_code),
    .resume_code(resume_code), .trig_code(trig_code), .auto_rts_en(auto_rts_en),
    .auto_cts_en(auto_cts_en), .rts_req(rts_req), .cts_n(cts_n),
    .char_done(char_done), .rts_n(rts_n), .tx_permit(tx_permit), .rx_trig(rx_trig));

  typedef struct packed {
    logic       aen;
    logic       req;
    logic [3:0] halt;
    logic [3:0] res;
    logic [3:0] trig;
    logic [6:0] cnt;
    logic       exp_rts;
    logic       exp_trig;
  } vec_t;

  // rows applied in order; rts expectation depends on the previous row
  localparam vec_t VEC [0:12] = '{
    '{1'b1, 1'b1, 4'd8,  4'd4,  4'd7,  7'd0,  1'b0, 1'b0}, // R3 empty: assert
    '{1'b1, 1'b1, 4'd8,  4'd4,  4'd3,  7'd20, 1'b0, 1'b1}, // R4 band holds low
    '{1'b1, 1'b1, 4'd8,  4'd4,  4'd7,  7'd32, 1'b1, 1'b1}, // R2 exactly halt
    '{1'b1, 1'b1, 4'd8,  4'd4,  4'd7,  7'd31, 1'b1, 1'b0}, // R4 band holds high
    '{1'b1, 1'b1, 4'd8,  4'd4,  4'd15, 7'd17, 1'b1, 1'b0}, // R4 one above resume
    '{1'b1, 1'b1, 4'd8,  4'd4,  4'd3,  7'd16, 1'b0, 1'b1}, // R3 exactly resume
    '{1'b1, 1'b1, 4'd8,  4'd4,  4'd15, 7'd64, 1'b1, 1'b1}, // R2 full
    '{1'b0, 1'b1, 4'd8,  4'd4,  4'd0,  7'd64, 1'b0, 1'b1}, // R6 manual ignores count
    '{1'b0, 1'b0, 4'd8,  4'd4,  4'd0,  7'd64, 1'b1, 1'b1}, // R6 manual request off
    '{1'b1, 1'b0, 4'd8,  4'd4,  4'd0,  7'd0,  1'b1, 1'b0}, // R6 auto needs request
    '{1'b1, 1'b1, 4'd2,  4'd5,  4'd1,  7'd10, 1'b1, 1'b1}, // R5 overlap: halt wins
    '{1'b1, 1'b1, 4'd0,  4'd0,  4'd0,  7'd0,  1'b1, 1'b0}, // R2 halt level zero
    '{1'b1, 1'b1, 4'd15, 4'd15, 4'd14, 7'd59, 1'b0, 1'b0}  // R3 top codes
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick_check_after();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rts_n in reset", rts_n, 1'b1);
    chk("R1 tx_permit in reset", tx_permit, 1'b1);
    chk("R1 rx_trig in reset", rx_trig, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      auto_rts_en = VEC[i].aen; rts_req = VEC[i].req;
      halt_code = VEC[i].halt; resume_code = VEC[i].res;
      trig_code = VEC[i].trig; rx_count = VEC[i].cnt;
      tick_check_after();
      chk($sformatf("rts row %0d (R2..R6)", i), rts_n, VEC[i].exp_rts);
      chk($sformatf("R7 trig row %0d", i), rx_trig, VEC[i].exp_trig);
    end

    // R7 boundary at the top trigger level (64)
    @(negedge clk); trig_code = 4'd15; rx_count = 7'd63;
    tick_check_after();
    chk("R7 63 below level 64", rx_trig, 1'b0);
    @(negedge clk); rx_count = 7'd64;
    tick_check_after();
    chk("R7 64 at level 64", rx_trig, 1'b1);

    // R9: CTS high without a boundary keeps permit
    @(negedge clk); cts_n = 1'b1;
    repeat (3) tick_check_after();
    chk("R9 no char_done keeps permit", tx_permit, 1'b1);
    @(negedge clk); char_done = 1'b1;
    tick_check_after();
    chk("R9 permit falls at boundary", tx_permit, 1'b0);
    @(negedge clk); char_done = 1'b0; cts_n = 1'b0;
    tick_check_after();
    chk("R9 permit stays low", tx_permit, 1'b0);
    tick_check_after();
    chk("R8 two edges: still low", tx_permit, 1'b0);
    tick_check_after();
    chk("R10 permit back on third edge", tx_permit, 1'b1);

    // R8: CTS and strobe together, sync delay protects permit
    @(negedge clk); cts_n = 1'b1; char_done = 1'b1;
    tick_check_after();
    chk("R8 first edge permit kept", tx_permit, 1'b1);
    tick_check_after();
    chk("R8 second edge permit kept", tx_permit, 1'b1);
    tick_check_after();
    chk("R8 third edge permit dropped", tx_permit, 1'b0);

    // R11: gating disabled
    @(negedge clk); auto_cts_en = 1'b0;
    tick_check_after();
    chk("R11 gate off restores permit", tx_permit, 1'b1);
    tick_check_after();
    chk("R11 strobe ignored when off", tx_permit, 1'b1);
    @(negedge clk); char_done = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule